// File: doc/BRIEF.md
# Pattern Playback and Spy Memory Bank

This block stands in for an eight-channel, 12-bit ADC during board tests and records what downstream logic computes. A host on an 8-bit register bus loads a 512-word pattern memory whose 96-bit words hold eight channel samples. It also loads a 512-entry trigger memory that holds one bit per channel. On a start pulse, both memories play back together, one word for each sample-clock enable. A third 512-word, 96-bit spy memory captures processed results on sample-clock enables, and the host later reads them out.

A configuration register gives the port of each memory to either the host or the sample-clock side. Words of 96 bits cross the byte bus as twelve bytes, least significant first. The twelfth byte completes the word and moves that memory's pointer. A status register reports a full flag and an empty flag for each memory, plus the playback state. A bit written to the configuration register clears every pointer.

Top module: `adc_pattern_spy`

## Requirements
- R1: After reset, all pointers are zero, `pat_out`, `trg_out` and `play_vld` are 0, and the status register reads 0x2A.
- R2: Twelve host writes at address 0x1F build one pattern word. The first byte is bits 7:0 and the twelfth is bits 95:88. The twelfth byte stores the word and moves the write pointer on.
- R3: With configuration bit 0 set, a `play_start` pulse restarts playback at word 0. On each later cycle with `smp_en` high, the next word appears on `pat_out` one cycle later, with `play_vld` high for that cycle.
- R4: Playback ends after word 511 has been presented. Status bit 6 (done) then reads 1 and status bit 7 (playing) reads 0.
- R5: Each host write at address 0x06 stores one trigger byte and moves the trigger pointer on. During playback, `trg_out` carries the trigger byte at the same index as `pat_out` when configuration bit 1 is set, and carries 0 otherwise.
- R6: With configuration bit 2 set, each cycle with both `spy_vld` and `smp_en` high stores `spy_din` in the spy memory. With bit 2 clear, `spy_vld` stores nothing.
- R7: Host reads at address 0x1C return a spy word least significant byte first. The twelfth read moves the read pointer on. A read of an empty memory returns 0 and moves nothing.
- R8: Once a memory holds 512 words since the last clear, its full flag is set and further writes to it are ignored.
- R9: A host read of the pattern or trigger memory while its configuration bit (0 or 1) gives that port to the sample clock returns 0 and does not move the read position.
- R10: Writing the configuration register (address 0x01) with bit 7 set clears all pointers, partial byte positions and the done flag. The low three bits are stored, and bit 7 is not kept.
- R11: The status register at address 0x02 holds these flags, from bit 0 upward: pattern full, pattern empty, trigger full, trigger empty, spy full, spy empty, done, playing. A memory is empty when its host read pointer equals its write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (moves read position) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational from address |
| smp_en | input | 1 | Sample-clock enable |
| play_start | input | 1 | Start playback pulse |
| pat_out | output | 96 | Played-back eight-channel sample word |
| trg_out | output | 8 | Played-back per-channel trigger bits |
| play_vld | output | 1 | Played-back word valid |
| spy_din | input | 96 | Processed result to capture |
| spy_vld | input | 1 | Capture request |

## Verification
A wrong pointer or byte position shows up on `host_rdata` within the same read: the byte comes from the wrong lane or the wrong word, so byte-wise compares against known words expose it at once. A playback counter that is off by one shifts every `pat_out` word by one sample, starting with the first. It also moves the done flag, which the bench sees after exactly 512 enabled cycles. Full and empty flags that are computed wrongly show in the status byte and in whether a 513th write is kept.

// File: rtl/adc_pattern_spy.sv
module adc_pattern_spy #(
  parameter int CH     = 8,
  parameter int SW     = 12,
  parameter int DEPTH  = 512,
  parameter logic [7:0] A_CFG  = 8'h01,
  parameter logic [7:0] A_STAT = 8'h02,
  parameter logic [7:0] A_TRG  = 8'h06,
  parameter logic [7:0] A_SPY  = 8'h1C,
  parameter logic [7:0] A_PAT  = 8'h1F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               smp_en,
  input  logic               play_start,
  output logic [CH*SW-1:0]   pat_out,
  output logic [CH-1:0]      trg_out,
  output logic               play_vld,
  input  logic [CH*SW-1:0]   spy_din,
  input  logic               spy_vld
);
  localparam int WW = CH*SW;
  localparam int NB = WW/8;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW+1;
  localparam int BW = $clog2(NB);
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);
  localparam logic [BW-1:0] LASTB = BW'(NB-1);
  localparam logic [AW-1:0] LASTA = AW'(DEPTH-1);

  logic [WW-1:0] pat_mem [DEPTH];
  logic [WW-1:0] spy_mem [DEPTH];
  logic [CH-1:0] trg_mem [DEPTH];

  logic [2:0]    cfg;
  logic [PW-1:0] pat_wp, pat_rp, trg_wp, trg_rp, spy_wp, spy_rp;
  logic [BW-1:0] pat_wb, pat_rb, spy_wb, spy_rb;
  logic [WW-9:0] pat_asm, spy_asm;
  logic [AW-1:0] play_ptr;
  logic          playing, done;

  wire clr   = host_wr && host_addr == A_CFG && host_wdata[7];
  wire pat_full  = pat_wp == FULLV;
  wire trg_full  = trg_wp == FULLV;
  wire spy_full  = spy_wp == FULLV;
  wire pat_empty = pat_rp == pat_wp;
  wire trg_empty = trg_rp == trg_wp;
  wire spy_empty = spy_rp == spy_wp;

  wire wr_pat = host_wr && host_addr == A_PAT && !pat_full;
  wire wr_trg = host_wr && host_addr == A_TRG && !trg_full;
  wire wr_spy = host_wr && host_addr == A_SPY && !cfg[2] && !spy_full;
  wire rd_pat = host_rd && host_addr == A_PAT && !cfg[0] && !pat_empty;
  wire rd_trg = host_rd && host_addr == A_TRG && !cfg[1] && !trg_empty;
  wire rd_spy = host_rd && host_addr == A_SPY && !spy_empty;
  wire cap    = cfg[2] && smp_en && spy_vld && !spy_full;

  wire pat_commit = wr_pat && pat_wb == LASTB;
  wire spy_commit = wr_spy && spy_wb == LASTB;

  logic [WW-1:0] pat_rword, spy_rword;
  assign pat_rword = pat_mem[pat_rp[AW-1:0]] >> (8*int'(pat_rb));
  assign spy_rword = spy_mem[spy_rp[AW-1:0]] >> (8*int'(spy_rb));

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CFG:  host_rdata = {5'b0, cfg};
      A_STAT: host_rdata = {playing, done, spy_empty, spy_full,
                            trg_empty, trg_full, pat_empty, pat_full};
      A_PAT:  if (!cfg[0] && !pat_empty) host_rdata = pat_rword[7:0];
      A_TRG:  if (!cfg[1] && !trg_empty) host_rdata = 8'(trg_mem[trg_rp[AW-1:0]]);
      A_SPY:  if (!spy_empty) host_rdata = spy_rword[7:0];
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= '0;
    else if (host_wr && host_addr == A_CFG) cfg <= host_wdata[2:0];

  // pattern memory: host packer on write, host unpacker on read
  always_ff @(posedge clk)
    if (pat_commit) pat_mem[pat_wp[AW-1:0]] <= {host_wdata, pat_asm};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pat_wp <= '0; pat_wb <= '0; pat_asm <= '0; pat_rp <= '0; pat_rb <= '0;
    end else if (clr) begin
      pat_wp <= '0; pat_wb <= '0; pat_rp <= '0; pat_rb <= '0;
    end else begin
      if (pat_commit) begin
        pat_wp <= pat_wp + 1'b1;
        pat_wb <= '0;
      end else if (wr_pat) begin
        pat_asm[8*int'(pat_wb) +: 8] <= host_wdata;
        pat_wb <= pat_wb + 1'b1;
      end
      if (rd_pat) begin
        if (pat_rb == LASTB) begin
          pat_rb <= '0;
          pat_rp <= pat_rp + 1'b1;
        end else pat_rb <= pat_rb + 1'b1;
      end
    end

  // trigger memory: one byte per word
  always_ff @(posedge clk)
    if (wr_trg) trg_mem[trg_wp[AW-1:0]] <= host_wdata[CH-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trg_wp <= '0; trg_rp <= '0;
    end else if (clr) begin
      trg_wp <= '0; trg_rp <= '0;
    end else begin
      if (wr_trg) trg_wp <= trg_wp + 1'b1;
      if (rd_trg) trg_rp <= trg_rp + 1'b1;
    end

  // spy memory: write from sample side or host, read by host
  always_ff @(posedge clk)
    if (cap) spy_mem[spy_wp[AW-1:0]] <= spy_din;
    else if (spy_commit) spy_mem[spy_wp[AW-1:0]] <= {host_wdata, spy_asm};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      spy_wp <= '0; spy_wb <= '0; spy_asm <= '0; spy_rp <= '0; spy_rb <= '0;
    end else if (clr) begin
      spy_wp <= '0; spy_wb <= '0; spy_rp <= '0; spy_rb <= '0;
    end else begin
      if (cap || spy_commit) spy_wp <= spy_wp + 1'b1;
      if (spy_commit) spy_wb <= '0;
      else if (wr_spy) begin
        spy_asm[8*int'(spy_wb) +: 8] <= host_wdata;
        spy_wb <= spy_wb + 1'b1;
      end
      if (rd_spy) begin
        if (spy_rb == LASTB) begin
          spy_rb <= '0;
          spy_rp <= spy_rp + 1'b1;
        end else spy_rb <= spy_rb + 1'b1;
      end
    end

  // playback engine
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      playing <= 1'b0; done <= 1'b0; play_ptr <= '0;
      play_vld <= 1'b0; pat_out <= '0; trg_out <= '0;
    end else if (clr) begin
      playing <= 1'b0; done <= 1'b0; play_ptr <= '0; play_vld <= 1'b0;
    end else begin
      play_vld <= 1'b0;
      if (play_start && cfg[0]) begin
        playing  <= 1'b1;
        done     <= 1'b0;
        play_ptr <= '0;
      end else if (playing && smp_en) begin
        pat_out  <= pat_mem[play_ptr];
        trg_out  <= cfg[1] ? trg_mem[play_ptr] : '0;
        play_vld <= 1'b1;
        if (play_ptr == LASTA) begin
          playing <= 1'b0;
          done    <= 1'b1;
        end else play_ptr <= play_ptr + 1'b1;
      end
    end

  assert_wp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wp <= FULLV && trg_wp <= FULLV && spy_wp <= FULLV);

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_full && host_wr && host_addr == A_TRG) |=> $stable(trg_wp));

  assert_play_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && smp_en && play_ptr == LASTA && !clr && !(play_start && cfg[0]))
      |=> (done && !playing));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spy_empty && host_rd && host_addr == A_SPY && !host_wr) |=> $stable(spy_rp));

  assert_spy_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[2] && !host_wr) |=> $stable(spy_wp));

  assert_vld_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_vld) |-> $past(playing));
endmodule

// File: tb/adc_pattern_spy_tb.sv
module adc_pattern_spy_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [95:0] PAT_V [NV] = '{
    96'h0123_4567_89AB_CDEF_0011_2233,
    96'hFFEE_DDCC_BBAA_9988_7766_5544,
    96'hA5A5_5A5A_F00F_0FF0_1234_8765,
    96'h0000_0001_8000_0000_DEAD_BEEF};
  localparam logic [7:0] TRG_V [NV] = '{8'h81, 8'h42, 8'h3C, 8'hFF};
  localparam logic [95:0] SPY_V [NV] = '{
    96'h1111_2222_3333_4444_5555_6666,
    96'hCAFE_F00D_0BAD_BEEF_7E57_AB1E,
    96'h0F0F_0F0F_F0F0_F0F0_0000_FFFF,
    96'h8000_0000_0000_0000_0000_0001};

  logic clk = 0, rst_n = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic host_wr = 0, host_rd = 0, smp_en = 0, play_start = 0, spy_vld = 0;
  logic [95:0] spy_din = 0;
  logic [7:0] host_rdata;
  logic [95:0] pat_out;
  logic [7:0] trg_out;
  logic play_vld;
  int checks = 0, fails = 0;
  logic [7:0] rb;
  logic [95:0] w;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pattern_spy u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .smp_en(smp_en), .play_start(play_start), .pat_out(pat_out),
    .trg_out(trg_out), .play_vld(play_vld), .spy_din(spy_din), .spy_vld(spy_vld));

  task automatic check(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [95:0] v);
    for (int b = 0; b < 12; b++) hw(a, v[8*b +: 8]);
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [95:0] v);
    for (int b = 0; b < 12; b++) begin
      logic [7:0] t;
      hr(a, t);
      v[8*b +: 8] = t;
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R11 reset state
    peek(8'h02, rb);
    check(rb == 8'h2A, "R1 R11 status after reset", rb, 8'h2A);
    check(pat_out == 0 && trg_out == 0 && play_vld == 0, "R1 outputs after reset", pat_out, 0);
    hr(8'h1F, rb);
    check(rb == 0, "R7 empty pattern read", rb, 0);

    // table: load pattern, trigger and host-written spy words
    for (int i = 0; i < NV; i++) begin
      wr_word(8'h1F, PAT_V[i]);
      hw(8'h06, TRG_V[i]);
      wr_word(8'h1C, SPY_V[i]);
    end
    peek(8'h02, rb);
    check(rb == 8'h00, "R11 status after loading", rb, 8'h00);

    // R9: gated read returns 0 and leaves position
    hw(8'h01, 8'h03);
    hr(8'h1F, rb);
    check(rb == 0, "R9 pattern read while sample-owned", rb, 0);
    hr(8'h06, rb);
    check(rb == 0, "R9 trigger read while sample-owned", rb, 0);
    hw(8'h01, 8'h00);
    peek(8'h01, rb);
    check(rb == 8'h00, "R10 cfg readback", rb, 0);

    for (int i = 0; i < NV; i++) begin
      rd_word(8'h1F, w);
      check(w == PAT_V[i], "R2 R9 pattern host readback", w, PAT_V[i]);
      hr(8'h06, rb);
      check(rb == TRG_V[i], "R5 trigger host readback", rb, TRG_V[i]);
      rd_word(8'h1C, w);
      check(w == SPY_V[i], "R7 spy host-written readback", w, SPY_V[i]);
    end
    peek(8'h02, rb);
    check(rb == 8'h2A, "R11 all empty after readback", rb, 8'h2A);

    // R3/R4/R5 playback with triggers
    hw(8'h01, 8'h03);
    @(negedge clk); play_start = 1; smp_en = 1;
    @(negedge clk); play_start = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      if (k < NV) begin
        check(play_vld && pat_out == PAT_V[k], "R3 playback word", pat_out, PAT_V[k]);
        check(trg_out == TRG_V[k], "R5 playback trigger", trg_out, TRG_V[k]);
      end
      if (k == 200) begin
        peek(8'h02, rb);
        check(rb[7:6] == 2'b10, "R4 playing mid-run", rb[7:6], 2'b10);
        k++;
      end
    end
    @(negedge clk);
    check(play_vld == 0, "R4 no output after last word", play_vld, 0);
    peek(8'h02, rb);
    check(rb[7:6] == 2'b01, "R4 done and stopped", rb[7:6], 2'b01);

    // R5: trigger gated to 0 when bit 1 clear
    hw(8'h01, 8'h01);
    @(negedge clk); play_start = 1;
    @(negedge clk); play_start = 0;
    @(negedge clk);
    check(pat_out == PAT_V[0] && trg_out == 0, "R5 trigger off", trg_out, 0);
    smp_en = 0;

    // R10 clear
    hw(8'h01, 8'h84);
    peek(8'h01, rb);
    check(rb == 8'h04, "R10 cfg keeps low bits", rb, 8'h04);
    peek(8'h02, rb);
    check(rb == 8'h2A, "R10 status after clear", rb, 8'h2A);

    // R6 capture; first request without smp_en must be dropped
    @(negedge clk); spy_din = 96'hBAD; spy_vld = 1; smp_en = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); spy_din = PAT_V[i]; smp_en = 1;
    end
    @(negedge clk); spy_vld = 0; smp_en = 0;
    hw(8'h01, 8'h00);
    @(negedge clk); spy_vld = 1; spy_din = 96'hEEEE; smp_en = 1;
    @(negedge clk); spy_vld = 0; smp_en = 0;
    for (int i = 0; i < NV; i++) begin
      rd_word(8'h1C, w);
      check(w == PAT_V[i], "R6 captured word", w, PAT_V[i]);
    end
    peek(8'h02, rb);
    check(rb[5] == 1, "R6 no capture with bit 2 clear", rb[5], 1);
    hr(8'h1C, rb);
    check(rb == 0, "R7 empty spy read returns 0", rb, 0);

    // R8 full trigger memory
    hw(8'h01, 8'h80);
    for (int i = 0; i < 512; i++) hw(8'h06, 8'(i) ^ 8'h5A);
    peek(8'h02, rb);
    check(rb[2] == 1 && rb[3] == 0, "R8 trigger full flag", rb, 8'h04);
    hw(8'h06, 8'hEE);
    for (int i = 0; i < 512; i++) begin
      hr(8'h06, rb);
      if (i == 0 || i == 511)
        check(rb == (8'(i) ^ 8'h5A), "R8 trigger fill readback", rb, 8'(i) ^ 8'h5A);
    end
    peek(8'h02, rb);
    check(rb[3] == 1, "R8 write past full ignored", rb[3], 1);
    hr(8'h06, rb);
    check(rb == 0, "R8 nothing after 512 entries", rb, 0);

    finish_run();
  end
endmodule